// File: doc/BRIEF.md
# Quantized 8x8 Forward DCT Engine

This block turns one 8x8 tile of unsigned 8-bit picture samples into 64 quantized frequency coefficients. The tile arrives as sixteen 32-bit words on a single wide input, and a one-cycle start pulse captures it. The engine first recentres each sample around zero. It then runs a separable two-dimensional discrete cosine transform as two one-dimensional passes, rows first and then columns. Each result is divided by the matching entry of a fixed luminance quantization table.

The coefficients come out one per cycle in row-major (u, v) order, u being the vertical frequency and v the horizontal one. They are flagged by a valid strobe, and a done strobe marks the final one. A start that arrives while a tile is in flight is dropped. The surrounding logic must wait for busy to fall before it offers the next tile. Zigzag reordering and entropy coding belong to later stages.

Top module: `dct8_quant`

## Requirements
- R1: The input bus holds 16 words of 32 bits. Word w occupies bits [32w+31:32w], with w = 2*row + half. Half 0 carries columns 0..3 and half 1 carries columns 4..7. Inside a word, the lowest-numbered column sits in bits 31:24 and the highest in bits 7:0.
- R2: Each sample has 128 subtracted exactly once before the transform.
- R3: Output (u,v) is round(cu*cv*S(u,v)/Q(u,v)), within ±1, where S is the sum over rows x and columns y of the shifted sample times cos((2x+1)uπ/16)·cos((2y+1)vπ/16). The factor ck is 1/√8 for k = 0 and √2/√8 otherwise. Q is the standard luminance table, whose first row is 16 11 10 16 24 40 51 61. Rounding is to nearest, with halves away from zero.
- R4: A tile of all 255 gives 64 at (0,0) and exactly 0 at every other position.
- R5: After start is accepted at a clock edge, the first coefficient is valid after the 65th following edge. Valid then stays high for exactly 64 consecutive cycles, in order u*8+v.
- R6: Done is high for exactly one cycle, which is the cycle of the 64th coefficient.
- R7: Start is accepted only while busy is low. A start while busy changes neither the outputs nor the timing of the tile in flight.
- R8: Busy is high from the cycle after the accepting edge until the last coefficient is presented, and busy is low in that last cycle.
- R9: A synchronous active-low reset clears busy, valid, done and the coefficient output, even in the middle of a tile.
- R10: Coefficients are 12-bit two's complement. For an all-zero tile the value at (0,0) is -64 (0xFC0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture the tile on this edge when idle |
| tile_words | input | 512 | Sixteen packed sample words (R1 layout) |
| busy | output | 1 | Tile in flight |
| out_valid | output | 1 | coef_out holds a coefficient |
| done | output | 1 | Marks the 64th coefficient |
| coef_out | output | 12 | Signed quantized coefficient |

## Verification
Every output is compared with a real-valued model in the bench. A byte-order or word-order slip in unpacking would move impulse tiles' energy to the wrong frequencies, so single-sample impulses are placed at the edge bytes of words. A tile of all 255 must give zeros at every AC position, which catches coefficient tables that are not symmetric. An all-zero tile exposes a level shift applied twice, or a wrong sign treatment in the rounding. A second start is injected mid-tile: a design that restarted would give the wrong count, the wrong timing or mixed data. A mid-tile reset checks that the outputs are cleared.

// File: rtl/dctq_pkg.sv
// Shared constants, state type and elaboration-time tables for the
// quantized 8x8 DCT. Assumes coefficients scaled by 2^14 (Q1.14).
package dctq_pkg;

    localparam int TILE_N     = 8;
    localparam int TILE_SIZE  = TILE_N * TILE_N;
    localparam int TILE_WORDS = 2 * TILE_N;
    localparam int PER_WORD   = TILE_N / 2;
    localparam int COEF_W     = 16;
    localparam int COEF_FRAC  = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2
    } dct_state_e;

    // Luminance quantization steps, row-major (u*8+v), entry 0 in the top byte.
    localparam logic [8*TILE_SIZE-1:0] LUMA_Q = {
        8'd16, 8'd11, 8'd10, 8'd16, 8'd24, 8'd40, 8'd51, 8'd61,
        8'd12, 8'd12, 8'd14, 8'd19, 8'd26, 8'd58, 8'd60, 8'd55,
        8'd14, 8'd13, 8'd16, 8'd24, 8'd40, 8'd57, 8'd69, 8'd56,
        8'd14, 8'd17, 8'd22, 8'd29, 8'd51, 8'd87, 8'd80, 8'd62,
        8'd18, 8'd22, 8'd37, 8'd56, 8'd68, 8'd109, 8'd103, 8'd77,
        8'd24, 8'd35, 8'd55, 8'd64, 8'd81, 8'd104, 8'd113, 8'd92,
        8'd49, 8'd64, 8'd78, 8'd87, 8'd103, 8'd121, 8'd120, 8'd101,
        8'd72, 8'd92, 8'd95, 8'd98, 8'd112, 8'd100, 8'd103, 8'd99
    };

    // Quantization step at row-major position idx.
    function automatic int quant_step(input int idx);
        return int'(LUMA_Q[8*(TILE_SIZE-1-idx) +: 8]);
    endfunction

    // Rounded 2^bits / step, so the divide becomes a multiply.
    function automatic int recip_of(input int idx, input int bits);
        int q;
        q = quant_step(idx);
        return ((1 << bits) + q / 2) / q;
    endfunction

    // 0.5*cos(m*pi/16) in Q1.14 for m = 0..8.
    function automatic int half_cos(input int m);
        case (m)
            0:       return 8192;
            1:       return 8035;
            2:       return 7568;
            3:       return 6811;
            4:       return 5793;
            5:       return 4551;
            6:       return 3135;
            7:       return 1598;
            default: return 0;
        endcase
    endfunction

    // Normalized basis value for frequency k at sample n, folded by symmetry.
    function automatic int basis(input int k, input int n);
        int m;
        if (k == 0) return 5793;
        m = ((2 * n + 1) * k) % 32;
        if (m > 16) m = 32 - m;
        if (m <= 8) return half_cos(m);
        return -half_cos(16 - m);
    endfunction

endpackage

// File: rtl/dctq_unpack.sv
// Splits the packed word bus into 64 level-shifted samples, row-major.
// Assumes word w = 2*row + half; lowest column in the top byte.
module dctq_unpack
    import dctq_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic [TILE_WORDS*PER_WORD*SAMPLE_W-1:0] words_i,
    output logic signed [SAMPLE_W:0]                samp_o [TILE_SIZE]
);
    localparam int WORD_W = PER_WORD * SAMPLE_W;
    localparam logic signed [SAMPLE_W:0] MID_CODE = (SAMPLE_W+1)'(1 << (SAMPLE_W - 1));

    for (genvar g = 0; g < TILE_SIZE; g++) begin : g_samp
        localparam int ROW = g / TILE_N;
        localparam int COL = g % TILE_N;
        localparam int WRD = 2 * ROW + COL / PER_WORD;
        localparam int LSB = WRD * WORD_W + (PER_WORD - 1 - COL % PER_WORD) * SAMPLE_W;
        // Zero-extend the byte and recentre it around zero.
        assign samp_o[g] = $signed({1'b0, words_i[LSB +: SAMPLE_W]}) - MID_CODE;
    end
endmodule

// File: rtl/dctq_dot8.sv
// Eight-term signed dot product, purely combinational.
// Assumes S_W leaves room for the sum of eight full-scale products.
module dctq_dot8
    import dctq_pkg::*;
#(
    parameter int A_W = 9,
    parameter int C_W = 16,
    parameter int S_W = 28
) (
    input  logic signed [A_W-1:0] a_i [TILE_N],
    input  logic signed [C_W-1:0] c_i [TILE_N],
    output logic signed [S_W-1:0] sum_o
);
    logic signed [S_W-1:0] prod [TILE_N];

    for (genvar j = 0; j < TILE_N; j++) begin : g_mul
        assign prod[j] = S_W'(a_i[j]) * S_W'(c_i[j]);
    end

    // Adds the lane products.
    always_comb begin
        sum_o = '0;
        for (int j = 0; j < TILE_N; j++) sum_o = sum_o + prod[j];
    end
endmodule

// File: rtl/dctq_quant.sv
// Scales a transform value by a reciprocal step, then rounds to nearest
// with halves away from zero and saturates to OUT_W bits.
// Assumes the result of the reciprocal multiply is shifted right by SHIFT.
module dctq_quant #(
    parameter int IN_W  = 33,
    parameter int RB    = 16,
    parameter int SHIFT = 33,
    parameter int OUT_W = 12
) (
    input  logic signed [IN_W-1:0]  val_i,
    input  logic        [RB:0]      recip_i,
    output logic signed [OUT_W-1:0] q_o
);
    localparam int PW = IN_W + RB + 2;
    localparam logic [PW-1:0] HALF   = PW'(1) << (SHIFT - 1);
    localparam logic [PW-1:0] MAXPOS = PW'((1 << (OUT_W - 1)) - 1);

    logic signed [PW-1:0] prod;
    logic [PW-1:0]        mag;
    logic [PW-1:0]        rnd;

    assign prod = PW'(val_i) * PW'($signed({1'b0, recip_i}));

    // Rounds the magnitude, restores the sign and clamps.
    always_comb begin
        mag = prod[PW-1] ? PW'(-prod) : PW'(prod);
        rnd = (mag + HALF) >> SHIFT;
        if (prod[PW-1]) begin
            if (rnd > MAXPOS + 1) q_o = OUT_W'(-(MAXPOS + 1));
            else                  q_o = OUT_W'(-rnd);
        end else begin
            if (rnd > MAXPOS)     q_o = OUT_W'(MAXPOS);
            else                  q_o = OUT_W'(rnd);
        end
    end
endmodule

// File: rtl/dctq_seq.sv
// Phase sequencer: idle, 64 row-pass cycles, 64 column-pass cycles.
// Assumes start is only honoured in the idle state.
module dctq_seq
    import dctq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic [5:0] cnt,
    output logic       accept,
    output logic       row_we,
    output logic       col_fire,
    output logic       last,
    output logic       busy
);
    dct_state_e state;

    assign accept   = (state == ST_IDLE) && start;
    assign row_we   = (state == ST_ROW);
    assign col_fire = (state == ST_COL);
    assign last     = col_fire && (cnt == 6'd63);
    assign busy     = (state != ST_IDLE);

    // Advances the phase and the position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= ST_ROW;
                end
                ST_ROW: begin
                    cnt <= cnt + 6'd1;
                    if (cnt == 6'd63) state <= ST_COL;
                end
                ST_COL: begin
                    cnt <= cnt + 6'd1;
                    if (cnt == 6'd63) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dct8_quant.sv
// Quantized 8x8 forward DCT. Captures a packed tile on start, runs a
// row pass into a transpose buffer, then a column pass that quantizes and
// streams 64 coefficients in row-major order.
// Assumes the caller waits for busy low before the next start.
module dct8_quant
    import dctq_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int OUT_W      = 12,
    parameter int MID_FRAC   = 3,
    parameter int RECIP_BITS = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start,
    input  logic [TILE_WORDS*PER_WORD*SAMPLE_W-1:0] tile_words,
    output logic                                    busy,
    output logic                                    out_valid,
    output logic                                    done,
    output logic signed [OUT_W-1:0]                 coef_out
);
    localparam int SHIFT_W   = SAMPLE_W + 1;
    localparam int ROW_ACC_W = SHIFT_W + COEF_W + 3;
    localparam int ROW_SH    = COEF_FRAC - MID_FRAC;
    localparam int MID_W     = SAMPLE_W + MID_FRAC + 3;
    localparam int COL_ACC_W = MID_W + COEF_W + 3;
    localparam int Q_SHIFT   = COEF_FRAC + MID_FRAC + RECIP_BITS;
    localparam logic signed [ROW_ACC_W-1:0] ROW_HALF = ROW_ACC_W'(1 << (ROW_SH - 1));

    logic signed [SHIFT_W-1:0]   unp     [TILE_SIZE];
    logic signed [SHIFT_W-1:0]   samp_q  [TILE_SIZE];
    logic signed [MID_W-1:0]     mid_q   [TILE_SIZE];
    logic signed [COEF_W-1:0]    coef_c  [TILE_N][TILE_N];
    logic        [RECIP_BITS:0]  recip_c [TILE_SIZE];
    logic signed [SHIFT_W-1:0]   row_a   [TILE_N];
    logic signed [COEF_W-1:0]    row_c   [TILE_N];
    logic signed [MID_W-1:0]     col_a   [TILE_N];
    logic signed [COEF_W-1:0]    col_c   [TILE_N];
    logic signed [ROW_ACC_W-1:0] row_sum;
    logic signed [ROW_ACC_W-1:0] row_rnd;
    logic signed [COL_ACC_W-1:0] col_sum;
    logic signed [OUT_W-1:0]     q_val;
    logic [5:0]                  cnt;
    logic                        accept;
    logic                        row_we;
    logic                        col_fire;
    logic                        last;

    // Constant basis and reciprocal tables built at elaboration.
    for (genvar k = 0; k < TILE_N; k++) begin : g_basis_k
        for (genvar n = 0; n < TILE_N; n++) begin : g_basis_n
            assign coef_c[k][n] = COEF_W'(basis(k, n));
        end
    end
    for (genvar g = 0; g < TILE_SIZE; g++) begin : g_recip
        assign recip_c[g] = (RECIP_BITS+1)'(recip_of(g, RECIP_BITS));
    end

    dctq_unpack #(.SAMPLE_W(SAMPLE_W)) u_unpack (
        .words_i (tile_words),
        .samp_o  (unp)
    );

    dctq_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cnt      (cnt),
        .accept   (accept),
        .row_we   (row_we),
        .col_fire (col_fire),
        .last     (last),
        .busy     (busy)
    );

    // Selects a sample row against a basis row, then a buffer column against a basis row.
    always_comb begin
        for (int j = 0; j < TILE_N; j++) begin
            row_a[j] = samp_q[{cnt[5:3], 3'(j)}];
            row_c[j] = coef_c[cnt[2:0]][j];
            col_a[j] = mid_q[{3'(j), cnt[2:0]}];
            col_c[j] = coef_c[cnt[5:3]][j];
        end
    end

    dctq_dot8 #(.A_W(SHIFT_W), .C_W(COEF_W), .S_W(ROW_ACC_W)) u_row_dot (
        .a_i   (row_a),
        .c_i   (row_c),
        .sum_o (row_sum)
    );

    dctq_dot8 #(.A_W(MID_W), .C_W(COEF_W), .S_W(COL_ACC_W)) u_col_dot (
        .a_i   (col_a),
        .c_i   (col_c),
        .sum_o (col_sum)
    );

    // Trims the row-pass sum to MID_FRAC fractional bits.
    assign row_rnd = (row_sum + ROW_HALF) >>> ROW_SH;

    dctq_quant #(
        .IN_W  (COL_ACC_W),
        .RB    (RECIP_BITS),
        .SHIFT (Q_SHIFT),
        .OUT_W (OUT_W)
    ) u_quant (
        .val_i   (col_sum),
        .recip_i (recip_c[cnt]),
        .q_o     (q_val)
    );

    // Captures the level-shifted tile when a start is accepted.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < TILE_SIZE; i++) samp_q[i] <= unp[i];
        end
    end

    // Writes one row-pass result per cycle into the transpose buffer.
    always_ff @(posedge clk) begin
        if (row_we) mid_q[cnt] <= MID_W'(row_rnd);
    end

    // Registers the streamed coefficient and its strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            coef_out  <= '0;
        end else begin
            out_valid <= col_fire;
            done      <= last;
            if (col_fire) coef_out <= q_val;
        end
    end
endmodule

// File: rtl/dct8_quant_chk.sv
// Protocol checker for dct8_quant, attached by bind.
// Assumes only the top-level ports are visible.
module dct8_quant_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic out_valid,
    input logic done
);
    logic [6:0] vcnt;
    logic [7:0] run;

    // Counts coefficients of the current tile.
    always_ff @(posedge clk) begin
        if (!rst_n || done) vcnt <= '0;
        else if (out_valid) vcnt <= vcnt + 7'd1;
    end

    // Counts cycles while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run <= '0;
        else                 run <= run + 8'd1;
    end

    a_r6_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid);
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> vcnt == 7'd63);
    a_r8_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |-> busy);
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r5_first_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> run == 8'd65);
endmodule

bind dct8_quant dct8_quant_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .done      (done)
);

// File: tb/test_dct8_quant.sv
// Self-checking bench: real-valued reference model, table of tile patterns,
// then directed tests for a start while busy and a reset in mid-tile.
module test_dct8_quant;
    localparam int    NPAT = 9;
    localparam int    PAT_KIND [NPAT] = '{0, 0, 1, 2, 3, 4, 4, 5, 5};
    localparam int    PAT_ARG  [NPAT] = '{255, 0, 0, 0, 0, 7, 991, 3, 12};
    localparam real   PI = 3.14159265358979;
    localparam int    QT [64] = '{
        16, 11, 10, 16, 24, 40, 51, 61,   12, 12, 14, 19, 26, 58, 60, 55,
        14, 13, 16, 24, 40, 57, 69, 56,   14, 17, 22, 29, 51, 87, 80, 62,
        18, 22, 37, 56, 68, 109, 103, 77, 24, 35, 55, 64, 81, 104, 113, 92,
        49, 64, 78, 87, 103, 121, 120, 101, 72, 92, 95, 98, 112, 100, 103, 99};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [511:0]      tile_words = '0;
    logic              busy;
    logic              out_valid;
    logic              done;
    logic signed [11:0] coef_out;

    int checks = 0;
    int failures = 0;
    int tile [64];
    int expv [64];
    int got  [64];
    int nval, first_at, done_at, done_cnt;

    always #5 clk = ~clk;

    dct8_quant i_dct8_quant (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tile_words (tile_words),
        .busy       (busy),
        .out_valid  (out_valid),
        .done       (done),
        .coef_out   (coef_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void build(input int kind, input int arg);
        int seed = arg;
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0: tile[i] = arg;
                1: tile[i] = 36 * (i % 8);
                2: tile[i] = 36 * (i / 8);
                3: tile[i] = (((i / 8) + (i % 8)) % 2 == 1) ? 255 : 0;
                4: begin seed = seed * 1103515245 + 12345; tile[i] = (seed >>> 16) & 255; end
                default: tile[i] = (i == arg) ? 255 : 128;
            endcase
        end
    endfunction

    // Packs per R1: word 2*row+half, lowest column in the top byte.
    function automatic logic [511:0] pack();
        logic [511:0] v = '0;
        for (int i = 0; i < 64; i++) begin
            int w = 2 * (i / 8) + (i % 8) / 4;
            int b = (i % 8) % 4;
            v[w*32 + 31 - 8*b -: 8] = 8'(tile[i]);
        end
        return v;
    endfunction

    // Real-valued model of R2/R3, halves rounded away from zero.
    function automatic void reference();
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                real s = 0.0, cu, cv, f;
                for (int x = 0; x < 8; x++)
                    for (int y = 0; y < 8; y++)
                        s += (tile[x*8+y] - 128) * $cos((2*x+1)*u*PI/16.0) * $cos((2*y+1)*v*PI/16.0);
                cu = (u == 0) ? 1.0/$sqrt(8.0) : $sqrt(2.0)/$sqrt(8.0);
                cv = (v == 0) ? 1.0/$sqrt(8.0) : $sqrt(2.0)/$sqrt(8.0);
                f = cu * cv * s / QT[u*8+v];
                expv[u*8+v] = (f >= 0.0) ? $rtoi($floor(f + 0.5)) : -$rtoi($floor(-f + 0.5));
            end
        end
    endfunction

    // Runs one tile; optionally injects a second start at cycle intr.
    task automatic run_tile(input int intr, input int rst_at);
        nval = 0; first_at = -1; done_at = -1; done_cnt = 0;
        @(negedge clk);
        tile_words = pack();
        start = 1'b1;
        for (int k = 1; k <= 140; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0;
                check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
            end
            if (k == intr) begin
                start = 1'b1;
                tile_words = ~tile_words;
            end
            if (k == intr + 1) start = 1'b0;
            if (k == rst_at) rst_n = 1'b0;
            if (k == rst_at + 1) begin
                check(busy == 1'b0 && out_valid == 1'b0 && done == 1'b0 && coef_out == 12'sd0,
                      "R9 mid-tile reset", int'({busy, out_valid, done}), 0);
                rst_n = 1'b1;
            end
            if (out_valid) begin
                if (first_at < 0) first_at = k;
                if (nval < 64) got[nval] = int'(coef_out);
                nval++;
            end
            if (done) begin done_cnt++; done_at = k; end
            if (k == 128 && rst_at > 200) check(busy == 1'b1, "R8 busy before last", int'(busy), 1);
            if (k == 129 && rst_at > 200) check(busy == 1'b0, "R8 busy low at last", int'(busy), 0);
            if (k == 135 && rst_at > 200) check(busy == 1'b0, "R7 no restart after ignored start", int'(busy), 0);
        end
    endtask

    task automatic check_handshake();
        check(first_at == 66, "R5 first valid cycle", first_at, 66);
        check(nval == 64, "R5 valid count", nval, 64);
        check(done_cnt == 1, "R6 done pulses", done_cnt, 1);
        check(done_at == 129, "R6 done with 64th", done_at, 129);
    endtask

    task automatic check_values(input string req);
        for (int i = 0; i < 64; i++) begin
            int d = got[i] - expv[i];
            check(d >= -1 && d <= 1, req, got[i], expv[i]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state.
        check(busy == 1'b0 && out_valid == 1'b0 && done == 1'b0 && coef_out == 12'sd0,
              "R9 reset state", int'({busy, out_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < NPAT; p++) begin
            build(PAT_KIND[p], PAT_ARG[p]);
            reference();
            run_tile(-10, 1000);
            check_handshake();
            if (PAT_KIND[p] == 5) check_values("R1 impulse placement");
            else                  check_values("R3 coefficient");
            if (PAT_KIND[p] == 0 && PAT_ARG[p] == 255) begin
                check(got[0] == 64, "R4 all-255 DC", got[0], 64);
                for (int i = 1; i < 64; i++) check(got[i] == 0, "R4 all-255 AC zero", got[i], 0);
            end
            if (PAT_KIND[p] == 0 && PAT_ARG[p] == 0) begin
                check(got[0] == -64, "R10 all-zero DC", got[0], -64);
                check(got[0] == -64, "R2 single level shift", got[0], -64);
            end
        end

        // R7: a start while busy must not disturb the tile in flight.
        build(4, 4242);
        reference();
        run_tile(40, 1000);
        check_handshake();
        check_values("R7 start while busy");

        // R9: reset in mid-tile, then a clean tile.
        build(1, 0);
        run_tile(-10, 30);
        check(nval == 0, "R9 no output after reset", nval, 0);
        build(2, 0);
        reference();
        run_tile(-10, 1000);
        check_handshake();
        check_values("R9 recovery after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule